// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable stand-in for a small serial EEPROM of 128 bytes. A host reaches it over a chip select, a serial clock and a serial data input, and reads results from a separate serial data output. Every instruction opens with a start bit, then carries a two-bit opcode and a seven-bit address. These decode into read, write, byte erase, whole-array erase, whole-array write, write enable and write disable.

Operations that modify the array are self-timed. After the host drops chip select to launch one, the model stays busy for a parameterised number of system clock cycles instead of milliseconds. Whenever chip select is high during that time, the data output reports busy as low and ready as high. The model samples its serial inputs with a fast system clock, so it fits in an FPGA prototype or a chip-level simulation of a board-management path. The array is a plain dual-port memory suited to block RAM, so the whole-array commands sweep it one word per cycle while busy.

Top module: `seep_top`

## Requirements
- R1: Synchronous reset leaves writes disabled, the busy timer idle and `sdout` low; array contents survive reset.
- R2: Input bits are sampled on rising edges of `sclk` while `csel` is high. Zeros before the first 1 are ignored. After that start bit come opcode bit 1, opcode bit 0, then address bits 6 down to 0.
- R3: Opcode 10 (read): after the edge that takes address bit 0, `sdout` is low as a dummy bit. The k-th following rising edge (k = 1..8) presents data bit 8-k, so the most significant bit comes first.
- R4: Opcode 01 (write) is followed by 8 data bits, most significant first. The byte is stored at the address when `csel` falls after all 8 bits.
- R5: Opcode 11 (erase) sets the addressed byte to 0xFF when `csel` falls.
- R6: Opcode 00 is decoded by address bits 6:5: 11 enables writes, 00 disables them, 10 sets all 128 bytes to 0xFF, and 01 takes 8 data bits and writes that value to all 128 bytes.
- R7: Write, erase, erase-all and write-all leave the array unchanged and start no busy period unless writes were enabled since the last disable or reset.
- R8: A committed modify operation makes the model busy for max(WR_CYCLES, DEPTH) cycles. While `csel` is high and no new instruction has started, `sdout` is low while busy and high once done.
- R9: Dropping `csel` ends the current instruction. A write frame cut short before its 8th data bit changes nothing. `sdout` is low whenever `csel` was low on the previous cycle.
- R10: Start bits received while busy are ignored, so an instruction sent during a busy period has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial data to the host: read data or ready/busy |

## Verification
The assertions assume that the serial inputs are synchronous to `clk`. They also assume each `sclk` level lasts at least two system clock cycles, so one edge detector sees every rising edge and the read data is ready before the first output bit is needed. The bench drives all inputs on falling `clk` edges and holds each `sclk` phase for three or more cycles. A modify command is never launched while the model is busy, except in the test that sends a frame on purpose to show it is ignored. The array is filled with known values before any location is compared, because the memory is not cleared by reset.

// File: rtl/seep_pkg.sv
package seep_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_CMD,
    FS_DATA,
    FS_READ,
    FS_HOLD
  } fsm_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_LOCK  = 2'b00;
  localparam logic [1:0] EX_FILLW = 2'b01;
  localparam logic [1:0] EX_FILLE = 2'b10;
  localparam logic [1:0] EX_OPEN  = 2'b11;
endpackage

// File: rtl/seep_edge.sv
module seep_edge (
  input  logic clk,
  input  logic rst,
  input  logic csel,
  input  logic sclk,
  output logic rise,
  output logic cfall
);
  logic sclk_q;
  logic csel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      csel_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      csel_q <= csel;
    end
  end

  assign rise  = sclk & ~sclk_q;
  assign cfall = csel_q & ~csel;
endmodule

// File: rtl/seep_ram.sv
module seep_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seep_timer.sv
module seep_timer #(
  parameter int DEPTH    = 128,
  parameter int DW       = 8,
  parameter int BUSY_LEN = 200,
  localparam int AW      = $clog2(DEPTH),
  localparam int TW      = $clog2(BUSY_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bulk,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          sw_we,
  output logic [AW-1:0] sw_addr,
  output logic [DW-1:0] sw_data
);
  logic [TW-1:0] left_q;
  logic [AW-1:0] idx_q;
  logic          act_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
      dat_q  <= '0;
    end else if (start) begin
      left_q <= TW'(BUSY_LEN);
      idx_q  <= '0;
      act_q  <= bulk;
      dat_q  <= data;
    end else begin
      if (left_q != '0) left_q <= left_q - 1'b1;
      if (act_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == AW'(DEPTH - 1)) act_q <= 1'b0;
      end
    end
  end

  assign busy    = (left_q != '0);
  assign sw_we   = act_q;
  assign sw_addr = idx_q;
  assign sw_data = dat_q;
endmodule

// File: rtl/seep_frame.sv
module seep_frame
  import seep_pkg::*;
#(
  parameter int AW  = 7,
  parameter int DW  = 8,
  localparam int FW = AW + 2,
  localparam int CW = $clog2(FW + DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csel,
  input  logic          rise,
  input  logic          cfall,
  input  logic          sdin,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic          go,
  output logic          go_bulk,
  output logic [DW-1:0] go_data,
  output logic          sdout,
  output logic          wen,
  output logic          idle
);
  fsm_t          st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sr;
  logic [DW-1:0] dat;
  logic [DW-1:0] rdsr;
  logic          wen_q, stat_q, sdo_q, go_q;
  logic          pend_q, pbulk_q, pfill_q, dbulk_q;

  logic [FW-1:0] sr_nx;
  logic [1:0]    op_nx;
  logic [1:0]    ext_nx;

  assign sr_nx  = {sr[FW-2:0], sdin};
  assign op_nx  = sr_nx[FW-1 -: 2];
  assign ext_nx = sr_nx[AW-1 -: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      sr      <= '0;
      dat     <= '0;
      rdsr    <= '0;
      wen_q   <= 1'b0;
      stat_q  <= 1'b0;
      sdo_q   <= 1'b0;
      go_q    <= 1'b0;
      pend_q  <= 1'b0;
      pbulk_q <= 1'b0;
      pfill_q <= 1'b0;
      dbulk_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (!csel) begin
        st     <= FS_IDLE;
        sdo_q  <= 1'b0;
        pend_q <= 1'b0;
        if (cfall && pend_q) begin
          go_q   <= 1'b1;
          stat_q <= 1'b1;
        end
      end else begin
        case (st)
          FS_IDLE: begin
            sdo_q <= stat_q & ~busy;
            if (rise && sdin && !busy) begin
              st     <= FS_CMD;
              cnt    <= '0;
              stat_q <= 1'b0;
              sdo_q  <= 1'b0;
            end
          end
          FS_CMD: begin
            sdo_q <= 1'b0;
            if (rise) begin
              sr  <= sr_nx;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(FW - 1)) begin
                cnt <= '0;
                case (op_nx)
                  OP_READ: st <= FS_READ;
                  OP_WRITE: begin
                    st      <= FS_DATA;
                    dbulk_q <= 1'b0;
                  end
                  OP_ERASE: begin
                    st      <= FS_HOLD;
                    pend_q  <= wen_q;
                    pbulk_q <= 1'b0;
                    pfill_q <= 1'b1;
                  end
                  default: begin
                    st <= FS_HOLD;
                    case (ext_nx)
                      EX_OPEN: wen_q <= 1'b1;
                      EX_LOCK: wen_q <= 1'b0;
                      EX_FILLE: begin
                        pend_q  <= wen_q;
                        pbulk_q <= 1'b1;
                        pfill_q <= 1'b1;
                      end
                      default: begin
                        st      <= FS_DATA;
                        dbulk_q <= 1'b1;
                      end
                    endcase
                  end
                endcase
              end
            end
          end
          FS_DATA: begin
            if (rise) begin
              dat <= {dat[DW-2:0], sdin};
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW - 1)) begin
                st      <= FS_HOLD;
                pend_q  <= wen_q;
                pbulk_q <= dbulk_q;
                pfill_q <= 1'b0;
              end
            end
          end
          FS_READ: begin
            if (rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == '0) begin
                sdo_q <= rd_data[DW-1];
                rdsr  <= {rd_data[DW-2:0], 1'b0};
              end else if (cnt < CW'(DW)) begin
                sdo_q <= rdsr[DW-1];
                rdsr  <= {rdsr[DW-2:0], 1'b0};
              end else begin
                sdo_q <= 1'b0;
                st    <= FS_HOLD;
              end
            end
          end
          default: sdo_q <= 1'b0;
        endcase
      end
    end
  end

  assign addr    = sr[AW-1:0];
  assign go      = go_q;
  assign go_bulk = pbulk_q;
  assign go_data = pfill_q ? {DW{1'b1}} : dat;
  assign sdout   = sdo_q;
  assign wen     = wen_q;
  assign idle    = (st == FS_IDLE);
endmodule

// File: rtl/seep_top.sv
module seep_top #(
  parameter int DEPTH     = 128,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic csel,
  input  logic sclk,
  input  logic sdin,
  output logic sdout
);
  localparam int AW       = $clog2(DEPTH);
  localparam int BUSY_LEN = (WR_CYCLES > DEPTH) ? WR_CYCLES : DEPTH;

  logic          rise, cfall;
  logic          go, go_bulk, busy, wen, fsm_idle;
  logic [AW-1:0] addr, sw_addr, waddr;
  logic [DW-1:0] go_data, sw_data, wdata, rd_data;
  logic          sw_we, ram_we;

  seep_edge u_edge (
    .clk(clk), .rst(rst), .csel(csel), .sclk(sclk),
    .rise(rise), .cfall(cfall)
  );

  seep_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst(rst), .csel(csel), .rise(rise), .cfall(cfall),
    .sdin(sdin), .busy(busy), .rd_data(rd_data), .addr(addr),
    .go(go), .go_bulk(go_bulk), .go_data(go_data), .sdout(sdout),
    .wen(wen), .idle(fsm_idle)
  );

  seep_timer #(.DEPTH(DEPTH), .DW(DW), .BUSY_LEN(BUSY_LEN)) u_timer (
    .clk(clk), .rst(rst), .start(go), .bulk(go_bulk), .data(go_data),
    .busy(busy), .sw_we(sw_we), .sw_addr(sw_addr), .sw_data(sw_data)
  );

  assign ram_we = sw_we | (go & ~go_bulk);
  assign waddr  = sw_we ? sw_addr : addr;
  assign wdata  = sw_we ? sw_data : go_data;

  seep_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(wdata),
    .raddr(addr), .rdata(rd_data)
  );
endmodule

// File: rtl/seep_chk.sv
module seep_chk #(
  parameter int BUSY_LEN = 200,
  localparam int BCW     = $clog2(BUSY_LEN + 2)
) (
  input logic clk,
  input logic rst,
  input logic csel,
  input logic sdout,
  input logic busy,
  input logic wen,
  input logic idle
);
  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sdout && !busy && !wen)); // R1

  AST_CSEL_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    !csel |=> !sdout); // R9

  AST_COMMIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen); // R7

  AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && idle) |=> idle); // R10

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    bcnt <= BCW'(BUSY_LEN)); // R8

  AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(csel) && $past(idle)) |-> !sdout); // R8
endmodule

bind seep_top seep_chk #(.BUSY_LEN(BUSY_LEN)) u_chk (
  .clk(clk), .rst(rst), .csel(csel), .sdout(sdout),
  .busy(busy), .wen(wen), .idle(fsm_idle)
);

// File: tb/sim_seep_top.sv
`timescale 1ns/1ps
module sim_seep_top;
  localparam int DEPTH    = 128;
  localparam int WRC      = 200;
  localparam int BUSY_LEN = (WRC > DEPTH) ? WRC : DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csel = 1'b0, sclk = 1'b0, sdin = 1'b0;
  logic sdout;

  int checks = 0;
  int errors = 0;

  logic [7:0] mdl [DEPTH];
  bit         mdl_wen = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] act_q [$];

  always #2 clk = ~clk;

  seep_top #(.DEPTH(DEPTH), .DW(8), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .csel(csel), .sclk(sclk), .sdin(sdin), .sdout(sdout)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, a}, {24'd0, e});
      end
    end
  end

  task automatic sbit(bit b);
    sdin = b;
    tick(2);
    sclk = 1'b1;
    tick(3);
    sclk = 1'b0;
    tick(1);
  endtask

  task automatic send_instr(bit [1:0] op, bit [6:0] a, int lead);
    csel = 1'b1;
    tick(2);
    repeat (lead) sbit(1'b0);
    sbit(1'b1);
    sbit(op[1]);
    sbit(op[0]);
    for (int i = 6; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic send_data(bit [7:0] d, int n);
    for (int i = 7; i >= 8 - n; i--) sbit(d[i]);
  endtask

  task automatic drop();
    csel = 1'b0;
    sdin = 1'b0;
    sclk = 1'b0;
    tick(2);
  endtask

  task automatic wait_ready();
    int n = 0;
    csel = 1'b1;
    tick(2);
    while (!sdout && n < 3000) begin
      tick(1);
      n++;
    end
    check("R8 ready seen", {31'd0, sdout}, 32'd1);
    drop();
  endtask

  task automatic do_write(bit [6:0] a, bit [7:0] d);
    send_instr(2'b01, a, 0);
    send_data(d, 8);
    drop();
    if (mdl_wen) begin
      mdl[a] = d;
      wait_ready();
    end
  endtask

  task automatic do_erase(bit [6:0] a);
    send_instr(2'b11, a, 0);
    drop();
    if (mdl_wen) begin
      mdl[a] = 8'hFF;
      wait_ready();
    end
  endtask

  task automatic do_fill(bit erase_all, bit [7:0] d);
    send_instr(2'b00, erase_all ? 7'b1000000 : 7'b0100000, 0);
    if (!erase_all) send_data(d, 8);
    drop();
    if (mdl_wen) begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = erase_all ? 8'hFF : d;
      wait_ready();
    end
  endtask

  task automatic do_enable(bit en);
    send_instr(2'b00, en ? 7'b1100000 : 7'b0000000, 0);
    drop();
    mdl_wen = en;
  endtask

  task automatic do_read(bit [6:0] a, string tag, int lead);
    logic [7:0] got;
    exp_q.push_back(mdl[a]);
    tag_q.push_back(tag);
    send_instr(2'b10, a, lead);
    check("R3 dummy bit low", {31'd0, sdout}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      sdin = 1'b0;
      tick(2);
      sclk = 1'b1;
      tick(3);
      got[7-k] = sdout;
      sclk = 1'b0;
      tick(1);
    end
    act_q.push_back(got);
    drop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R1 sdout low after reset", {31'd0, sdout}, 32'd0);

    // R1 / R7: fill with zeros, then reset must disable writes but keep data
    do_enable(1'b1);
    do_fill(1'b0, 8'h00);
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    mdl_wen = 1'b0;
    tick(2);
    check("R1 sdout low after second reset", {31'd0, sdout}, 32'd0);
    do_erase(7'd3);
    do_read(7'd3, "R7 erase ignored after reset", 0);
    do_read(7'd90, "R1 array kept over reset", 0);

    // R4 / R3 / R2
    do_enable(1'b1);
    do_write(7'h00, 8'hA5);
    do_write(7'h7F, 8'h5A);
    do_write(7'h40, 8'h81);
    do_read(7'h00, "R4 write addr 0x00", 0);
    do_read(7'h7F, "R4 write addr 0x7F", 0);
    do_read(7'h40, "R2 read with leading zeros", 3);

    // R5
    do_erase(7'h40);
    do_read(7'h40, "R5 erase to FF", 0);
    do_read(7'h00, "R5 neighbour untouched", 0);

    // R6
    do_fill(1'b0, 8'h96);
    do_read(7'h00, "R6 write-all low", 0);
    do_read(7'h7F, "R6 write-all high", 0);
    do_fill(1'b1, 8'h00);
    do_read(7'h21, "R6 erase-all", 0);
    do_read(7'h7F, "R6 erase-all top", 0);

    // R8: busy length measured from chip select drop
    send_instr(2'b01, 7'h11, 0);
    send_data(8'h3C, 8);
    csel = 1'b0;
    sdin = 1'b0;
    mdl[7'h11] = 8'h3C;
    n = 0;
    tick(2);
    n += 2;
    csel = 1'b1;
    tick(2);
    n += 2;
    check("R8 busy reads low", {31'd0, sdout}, 32'd0);
    while (!sdout && n < 3000) begin
      tick(1);
      n++;
    end
    checks++;
    if (n < BUSY_LEN + 1 || n > BUSY_LEN + 5) begin
      errors++;
      $display("FAIL R8 busy length: actual %0d expected %0d..%0d", n, BUSY_LEN + 1, BUSY_LEN + 5);
    end
    drop();
    do_read(7'h11, "R8 data after busy", 0);

    // R9: short write frame
    send_instr(2'b01, 7'h12, 0);
    send_data(8'h00, 5);
    drop();
    check("R9 sdout low after drop", {31'd0, sdout}, 32'd0);
    do_read(7'h12, "R9 aborted write", 0);

    // R10: frame during busy is ignored
    send_instr(2'b01, 7'h14, 0);
    send_data(8'h11, 8);
    drop();
    mdl[7'h14] = 8'h11;
    send_instr(2'b01, 7'h15, 0);
    send_data(8'h22, 8);
    drop();
    wait_ready();
    do_read(7'h14, "R10 first write kept", 0);
    do_read(7'h15, "R10 write during busy ignored", 0);

    // R7: disabled writes
    do_enable(1'b0);
    do_write(7'h16, 8'h77);
    do_fill(1'b1, 8'h00);
    do_read(7'h16, "R7 write blocked", 0);
    do_read(7'h11, "R7 erase-all blocked", 0);

    tick(10);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule